// File: doc/BRIEF.md
# Mixed-Decay H-Bridge Chopper Controller

This block is the digital control core of a full-bridge DC motor driver. It turns two command inputs into four gate enables, one high-side and one low-side enable for each bridge leg. It also runs fixed off-time current chopping. In drive, a digital current-trip input ends the on-phase. The bridge then decays the winding current in two halves. The first half is fast decay, on the opposite diagonal. The second half is slow decay, with both low sides on. Drive then resumes. All four switches are forced off for a dead-time interval between any two conducting states.

During decay the recirculating switches are turned on for synchronous rectification. A zero-current detect input cuts them off so that the load current cannot reverse. For a blanking window at the start of each on-phase the current-trip input is ignored. The blanking, off-time and dead-time lengths are parameters in clock cycles. One enable input carries standby and fault gating from outside the block. Deasserting it forces every switch off at once.

Top module: `hbc_top`

## Requirements
- R1: Command `dir_a_i=1, dir_b_i=0` selects forward drive, with `hs_o[0]` and `ls_o[1]` on. Command `dir_a_i=0, dir_b_i=1` selects reverse drive, with `hs_o[1]` and `ls_o[0]` on.
- R2: Command `dir_a_i=1, dir_b_i=1` selects brake, with `ls_o=2'b11` and `hs_o=2'b00`.
- R3: Command `dir_a_i=0, dir_b_i=0` (coast) and active reset both give all four enables low.
- R4: Every change of conducting state, including any change of command, first holds all four enables low for exactly DEAD_CYC cycles. The only exception is a drop of the enable input.
- R5: In the first BLANK_CYC cycles of each drive phase the trip input is ignored.
- R6: A trip sampled after the blanking window ends drive. After a dead interval, fast decay turns on the diagonal opposite to the drive diagonal for OFF_CYC/2 cycles.
- R7: After fast decay and a dead interval, slow decay turns on both low sides for OFF_CYC - OFF_CYC/2 cycles. After a further dead interval, drive resumes on the diagonal of the current command.
- R8: When zero-current detect is sampled high during fast or slow decay, all decay switches are off from the next cycle until the off-time ends.
- R9: A command that differs from the chopped drive direction, applied during the off-time, aborts the chop. The new command is applied after one dead interval.
- R10: With `en_i` low, all enables are low in the same cycle. When `en_i` returns, the block starts from coast, so a non-coast command passes through a dead interval first.
- R11: The high-side and low-side enables of the same leg are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable (standby and fault gating) |
| dir_a_i | input | 1 | Command input A |
| dir_b_i | input | 1 | Command input B |
| trip_i | input | 1 | Current-trip comparator, high when the current limit is reached |
| zero_i | input | 1 | Zero-current detect |
| hs_o | output | 2 | High-side enables, index 0 = leg A, index 1 = leg B |
| ls_o | output | 2 | Low-side enables, index 0 = leg A, index 1 = leg B |

## Verification
A wrong sequencer phase or a wrong counter value shows up at the gate outputs within one cycle. It appears as a missing or extra all-off cycle, a decay pattern on the wrong diagonal, or a phase that is one cycle too long or too short. A zero-current flag that is not set, or not cleared, shows as decay switches that stay on in the cycle after detection, or as switches that stay off in the next off-time. The bench runs a cycle model of the requirements alongside the design and compares all four enables on every cycle, so such a fault is reported in the cycle it first appears.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [2:0] {
    MD_COAST = 3'd0,
    MD_FWD   = 3'd1,
    MD_REV   = 3'd2,
    MD_BRAKE = 3'd3,
    MD_FAST  = 3'd4,
    MD_SLOW  = 3'd5
  } mode_e;

  function automatic logic is_decay(mode_e m);
    return (m == MD_FAST) || (m == MD_SLOW);
  endfunction

  function automatic logic is_drive(mode_e m);
    return (m == MD_FWD) || (m == MD_REV);
  endfunction

  function automatic mode_e drive_of(logic rev);
    return rev ? MD_REV : MD_FWD;
  endfunction

endpackage

// File: rtl/hbc_cmd_decode.sv
module hbc_cmd_decode
  import hbc_pkg::*;
(
  input  logic  dir_a_i,
  input  logic  dir_b_i,
  output mode_e mode_o
);

  always_comb begin
    unique case ({dir_a_i, dir_b_i})
      2'b10:   mode_o = MD_FWD;
      2'b01:   mode_o = MD_REV;
      2'b11:   mode_o = MD_BRAKE;
      default: mode_o = MD_COAST;
    endcase
  end

endmodule

// File: rtl/hbc_chop_seq.sv
module hbc_chop_seq
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 200,
  parameter int OFF_CYC   = 5000,
  parameter int DEAD_CYC  = 20,
  parameter int CW        = 13
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  mode_e cmd_mode_i,
  input  logic  trip_i,
  input  logic  zero_i,
  output logic  dead_o,
  output mode_e mode_o,
  output logic  rev_o,
  output logic  zcut_o,
  output logic  decay_o,
  output logic  blank_o
);

  localparam int FAST_CYC = OFF_CYC / 2;
  localparam int SLOW_CYC = OFF_CYC - FAST_CYC;
  localparam logic [CW-1:0] DEAD_LD  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC);
  localparam logic [CW-1:0] FAST_LD  = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] SLOW_LD  = CW'(SLOW_CYC - 1);

  logic          dead_q, dead_d;
  mode_e         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rev_q, rev_d;
  logic          zcut_q, zcut_d;
  mode_e         drv;

  assign drv = drive_of(rev_q);

  always_comb begin
    dead_d = dead_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    rev_d  = rev_q;
    if (!en_i) begin
      dead_d = 1'b0;
      mode_d = MD_COAST;
      cnt_d  = '0;
    end else if (dead_q) begin
      // retarget while all-off unless the chop still matches the command
      if (!(is_decay(mode_q) && cmd_mode_i == drv)) mode_d = cmd_mode_i;
      if (cnt_q == '0) begin
        dead_d = 1'b0;
        case (mode_d)
          MD_FWD, MD_REV: begin
            cnt_d = BLANK_LD;
            rev_d = (mode_d == MD_REV);
          end
          MD_FAST: cnt_d = FAST_LD;
          MD_SLOW: cnt_d = SLOW_LD;
          default: cnt_d = '0;
        endcase
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else begin
      case (mode_q)
        MD_FWD, MD_REV: begin
          if (cmd_mode_i != mode_q) begin
            dead_d = 1'b1; mode_d = cmd_mode_i; cnt_d = DEAD_LD;
          end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
          end else if (trip_i) begin
            dead_d = 1'b1; mode_d = MD_FAST; cnt_d = DEAD_LD;
          end
        end
        MD_FAST: begin
          if (cmd_mode_i != drv) begin
            dead_d = 1'b1; mode_d = cmd_mode_i; cnt_d = DEAD_LD;
          end else if (cnt_q == '0) begin
            dead_d = 1'b1; mode_d = MD_SLOW; cnt_d = DEAD_LD;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        MD_SLOW: begin
          if (cmd_mode_i != drv) begin
            dead_d = 1'b1; mode_d = cmd_mode_i; cnt_d = DEAD_LD;
          end else if (cnt_q == '0) begin
            dead_d = 1'b1; mode_d = drv; cnt_d = DEAD_LD;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: begin
          if (cmd_mode_i != mode_q) begin
            dead_d = 1'b1; mode_d = cmd_mode_i; cnt_d = DEAD_LD;
          end
        end
      endcase
    end
  end

  always_comb begin
    zcut_d = zcut_q;
    if (!en_i)                                  zcut_d = 1'b0;
    else if (!dead_q && is_decay(mode_q) && zero_i) zcut_d = 1'b1;
    else if (!dead_q && !is_decay(mode_q))      zcut_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q <= 1'b0;
      mode_q <= MD_COAST;
      cnt_q  <= '0;
      rev_q  <= 1'b0;
      zcut_q <= 1'b0;
    end else begin
      dead_q <= dead_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      rev_q  <= rev_d;
      zcut_q <= zcut_d;
    end
  end

  assign dead_o  = dead_q;
  assign mode_o  = mode_q;
  assign rev_o   = rev_q;
  assign zcut_o  = zcut_q;
  assign decay_o = !dead_q && is_decay(mode_q);
  assign blank_o = !dead_q && is_drive(mode_q) && (cnt_q != '0);

endmodule

// File: rtl/hbc_gate_map.sv
module hbc_gate_map
  import hbc_pkg::*;
(
  input  logic       en_i,
  input  logic       dead_i,
  input  mode_e      mode_i,
  input  logic       rev_i,
  input  logic       zcut_i,
  output logic [1:0] hs_o,
  output logic [1:0] ls_o
);

  always_comb begin
    hs_o = 2'b00;
    ls_o = 2'b00;
    if (en_i && !dead_i) begin
      case (mode_i)
        MD_FWD:   begin hs_o = 2'b01; ls_o = 2'b10; end
        MD_REV:   begin hs_o = 2'b10; ls_o = 2'b01; end
        MD_BRAKE: ls_o = 2'b11;
        MD_FAST: if (!zcut_i) begin
          // opposite diagonal of the chopped drive
          hs_o = rev_i ? 2'b01 : 2'b10;
          ls_o = rev_i ? 2'b10 : 2'b01;
        end
        MD_SLOW: if (!zcut_i) ls_o = 2'b11;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hbc_top.sv
module hbc_top
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 200,
  parameter int OFF_CYC   = 5000,
  parameter int DEAD_CYC  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       trip_i,
  input  logic       zero_i,
  output logic [1:0] hs_o,
  output logic [1:0] ls_o
);

  localparam int MAX_A = (BLANK_CYC > OFF_CYC) ? BLANK_CYC : OFF_CYC;
  localparam int MAX_V = (MAX_A > DEAD_CYC) ? MAX_A : DEAD_CYC;
  localparam int CW    = $clog2(MAX_V + 1);

  mode_e cmd_mode;
  mode_e seq_mode;
  logic  seq_dead, seq_rev, seq_zcut, seq_decay, seq_blank;

  hbc_cmd_decode u_dec (
    .dir_a_i (dir_a_i),
    .dir_b_i (dir_b_i),
    .mode_o  (cmd_mode)
  );

  hbc_chop_seq #(
    .BLANK_CYC (BLANK_CYC),
    .OFF_CYC   (OFF_CYC),
    .DEAD_CYC  (DEAD_CYC),
    .CW        (CW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cmd_mode_i (cmd_mode),
    .trip_i     (trip_i),
    .zero_i     (zero_i),
    .dead_o     (seq_dead),
    .mode_o     (seq_mode),
    .rev_o      (seq_rev),
    .zcut_o     (seq_zcut),
    .decay_o    (seq_decay),
    .blank_o    (seq_blank)
  );

  hbc_gate_map u_map (
    .en_i   (en_i),
    .dead_i (seq_dead),
    .mode_i (seq_mode),
    .rev_i  (seq_rev),
    .zcut_i (seq_zcut),
    .hs_o   (hs_o),
    .ls_o   (ls_o)
  );

endmodule

// File: rtl/hbc_chk.sv
module hbc_chk
  import hbc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       zero_i,
  input logic [1:0] hs_i,
  input logic [1:0] ls_i,
  input logic       decay_i,
  input logic       blank_i,
  input mode_e      cmd_mode_i,
  input mode_e      mode_i
);

  logic [3:0] g;
  assign g = {hs_i, ls_i};

  p_leg_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_i & ls_i) == 2'b00);

  p_en_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (g == 4'b0000));

  p_dead_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(g) != 4'b0000 && g != 4'b0000) |-> (g == $past(g)));

  p_zero_cut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decay_i && zero_i) |=> (!decay_i || g == 4'b0000));

  p_blank_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && en_i && cmd_mode_i == mode_i) |=> (!en_i || g == $past(g)));

endmodule

bind hbc_top hbc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .zero_i     (zero_i),
  .hs_i       (hs_o),
  .ls_i       (ls_o),
  .decay_i    (seq_decay),
  .blank_i    (seq_blank),
  .cmd_mode_i (cmd_mode),
  .mode_i     (seq_mode)
);

// File: tb/test_hbc_top.sv
`timescale 1ns/1ps
module test_hbc_top;

  localparam int BLANK = 3;
  localparam int OFFC  = 11;
  localparam int DEAD  = 2;
  localparam int FASTN = OFFC / 2;
  localparam int SLOWN = OFFC - FASTN;

  localparam int PH_COAST = 0, PH_FWD = 1, PH_REV = 2, PH_BRK = 3;
  localparam int PH_FAST = 4, PH_SLOW = 5, PH_DEAD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic a = 1'b0, b = 1'b0, trip = 1'b0, zero = 1'b0;
  logic [1:0] hs, ls;
  wire  [3:0] g = {hs, ls};

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbc_top #(.BLANK_CYC(BLANK), .OFF_CYC(OFFC), .DEAD_CYC(DEAD)) i_hbc_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_a_i(a), .dir_b_i(b),
    .trip_i(trip), .zero_i(zero), .hs_o(hs), .ls_o(ls)
  );

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // ---- cycle model built from the requirements ----
  int m_ph = PH_COAST, m_tgt = PH_COAST, m_age = 0;
  bit m_rev = 0, m_zc = 0;

  function automatic int cmd_of(logic ca, logic cb);
    if (ca && !cb) return PH_FWD;
    if (!ca && cb) return PH_REV;
    if (ca && cb)  return PH_BRK;
    return PH_COAST;
  endfunction

  function automatic logic [3:0] exp_g();
    if (!en) return 4'b0000;
    case (m_ph)
      PH_FWD:  return 4'b0110;
      PH_REV:  return 4'b1001;
      PH_BRK:  return 4'b0011;
      PH_FAST: return m_zc ? 4'b0000 : (m_rev ? 4'b0110 : 4'b1001);
      PH_SLOW: return m_zc ? 4'b0000 : 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string ph_tag();
    case (m_ph)
      PH_FWD, PH_REV: return "R1";
      PH_BRK:  return "R2";
      PH_COAST: return "R3";
      PH_DEAD: return "R4";
      PH_FAST: return m_zc ? "R8" : "R6";
      default: return m_zc ? "R8" : "R7";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = PH_COAST; m_tgt = PH_COAST; m_age = 0; m_rev = 0; m_zc = 0;
    end else if (!en) begin
      m_ph = PH_COAST; m_age = 0; m_zc = 0;
    end else begin
      int c, drv;
      c = cmd_of(a, b);
      drv = m_rev ? PH_REV : PH_FWD;
      if ((m_ph == PH_FAST || m_ph == PH_SLOW) && zero) m_zc = 1;
      else if (m_ph < PH_FAST) m_zc = 0;
      case (m_ph)
        PH_DEAD: begin
          if (!((m_tgt == PH_FAST || m_tgt == PH_SLOW) && c == drv)) m_tgt = c;
          if (m_age == DEAD - 1) begin
            m_ph = m_tgt; m_age = 0;
            if (m_tgt == PH_FWD || m_tgt == PH_REV) m_rev = (m_tgt == PH_REV);
          end else m_age++;
        end
        PH_FAST: begin
          if (c != drv) begin m_ph = PH_DEAD; m_tgt = c; m_age = 0; end
          else if (m_age == FASTN - 1) begin m_ph = PH_DEAD; m_tgt = PH_SLOW; m_age = 0; end
          else m_age++;
        end
        PH_SLOW: begin
          if (c != drv) begin m_ph = PH_DEAD; m_tgt = c; m_age = 0; end
          else if (m_age == SLOWN - 1) begin m_ph = PH_DEAD; m_tgt = drv; m_age = 0; end
          else m_age++;
        end
        default: begin
          if (c != m_ph) begin m_ph = PH_DEAD; m_tgt = c; m_age = 0; end
          else if ((m_ph == PH_FWD || m_ph == PH_REV) && m_age >= BLANK && trip) begin
            m_ph = PH_DEAD; m_tgt = PH_FAST; m_age = 0;
          end else if (m_age < 1000000) m_age++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(ph_tag(), g, exp_g());
      chk("R11", {2'b00, hs & ls}, 4'b0000);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): run did not complete");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hold;
    void'($urandom(32'd20240517));
    step(3);
    chk("R3 reset", g, 4'b0000);
    rst_n = 1'b1;
    step(1);
    // forward: dead interval, then drive
    a = 1; b = 0;
    step(DEAD); chk("R4 dead before drive", g, 4'b0000);
    step(1);    chk("R1 forward", g, 4'b0110);
    // blanking and full chop
    trip = 1;
    step(BLANK); chk("R5 trip blanked", g, 4'b0110);
    step(1);     chk("R6 dead after trip", g, 4'b0000); trip = 0;
    step(DEAD);  chk("R6 fast decay start", g, 4'b1001);
    step(FASTN - 1); chk("R6 fast decay last", g, 4'b1001);
    step(1);     chk("R4 dead after fast", g, 4'b0000);
    step(DEAD);  chk("R7 slow decay start", g, 4'b0011);
    step(SLOWN - 1); chk("R7 slow decay last", g, 4'b0011);
    step(1);     chk("R4 dead after slow", g, 4'b0000);
    step(DEAD);  chk("R7 drive resumes", g, 4'b0110);
    // zero-current cut
    trip = 1;
    step(BLANK + 1); trip = 0;
    step(DEAD);  chk("R6 fast before zero", g, 4'b1001);
    zero = 1;
    step(1); zero = 0; chk("R8 cut next cycle", g, 4'b0000);
    step(FASTN - 2); chk("R8 fast stays cut", g, 4'b0000);
    step(1 + DEAD);  chk("R8 slow stays cut", g, 4'b0000);
    // abort during off-time
    a = 0; b = 1;
    step(1);        chk("R9 abort dead", g, 4'b0000);
    step(DEAD - 1); chk("R9 abort dead end", g, 4'b0000);
    step(1);        chk("R9 new command", g, 4'b1001);
    // brake
    a = 1; b = 1;
    step(DEAD + 1); chk("R2 brake", g, 4'b0011);
    // enable drop
    en = 0; #1; chk("R10 off same cycle", g, 4'b0000);
    step(1); en = 1;
    step(DEAD); chk("R10 restart through dead", g, 4'b0000);
    step(1);    chk("R10 brake after restart", g, 4'b0011);
    // coast
    a = 0; b = 0;
    step(DEAD + 1); chk("R3 coast", g, 4'b0000);
    // reverse chop uses the other diagonal
    a = 0; b = 1;
    step(DEAD + 1); chk("R1 reverse", g, 4'b1001);
    trip = 1;
    step(BLANK + 1); trip = 0;
    step(DEAD); chk("R6 reverse fast diagonal", g, 4'b0110);
    // random phase, checked by the model each cycle
    hold = 0;
    for (int i = 0; i < 6000; i++) begin
      step(1);
      if (hold == 0) begin
        a = 1'($urandom_range(0, 1));
        b = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 3) != 0) begin a = 1; b = ($urandom_range(0, 3) == 0); end
        hold = $urandom_range(1, 60);
      end else hold--;
      trip = ($urandom_range(0, 5) == 0);
      zero = ($urandom_range(0, 19) == 0);
      en   = ($urandom_range(0, 299) != 0);
    end
    step(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule